// File: doc/BRIEF.md
# Start/Stop Framed Serial Character Receiver

This block recovers characters from a single serial line that rests at logic 1 between characters. It runs from a local clock that is a fixed multiple of the bit rate, 16 clocks per bit by default. A character begins with one low start bit. Data bits follow, least significant first, and a run of 5 to 8 of them is chosen at run time. An optional parity bit comes next, then one or two high stop bits. The line may stay idle for any length of time after the stop element.

The receiver passes the line through a two-flop synchroniser and watches for a falling edge. Each start edge resets the bit timing, so any rate mismatch built up during one character does not carry into the next. The start bit is confirmed at its midpoint. A low that has already gone away by then counts as noise, and the receiver returns to waiting. Every later bit is sampled one bit time after the one before, so each sample lands near the middle of its bit.

At the middle of the final stop bit, the receiver presents the character with a one-cycle strobe. Parity-error and framing-error flags are valid in that same cycle. The controller has six encoded states that make up two behavioural phases:
- The waiting phase is `RX_IDLE`.
- The receiving phase covers `RX_START`, `RX_DATA`, `RX_PARITY`, `RX_STOP1` and `RX_STOP2`.

The transitions are:
- `RX_IDLE` goes to `RX_START` on a falling edge.
- `RX_START` goes to `RX_DATA` when the line is still low at the half-bit tick. If the line is high there, it goes back to `RX_IDLE` (glitch reject).
- `RX_DATA` stays in place until the last data bit is taken. It then goes to `RX_PARITY` when parity is enabled, or to `RX_STOP1` otherwise.
- `RX_PARITY` goes to `RX_STOP1`.
- `RX_STOP1` goes to `RX_STOP2` when two stop bits are configured. Otherwise it goes to `RX_IDLE` and emits the character.
- `RX_STOP2` goes to `RX_IDLE` and emits the character.

Top module: `async_char_rx`

## Requirements
- R1: After reset, char_valid, parity_err and frame_err are 0 and char_data is all zeros.
- R2: The line idles high. A character starts only on a high-to-low transition that is still low half a bit time (8 clocks) later. A shorter low pulse produces no character and does not disturb the next real character.
- R3: cfg_data_bits selects the character length: code 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Bits arrive least significant first and are placed at char_data[0] upward. Positions above the configured length read 0.
- R4: Each bit is sampled once, near its middle: half a bit time after the start edge, then at intervals of one bit time (16 clocks). Values that are wrong only in the first or last 3 clocks of a bit do not change the result.
- R5: With cfg_parity_en=1, a parity bit follows the data. With cfg_parity_odd=0 the ones in data plus parity must be even, and with cfg_parity_odd=1 they must be odd. A mismatch sets parity_err with the strobe. With cfg_parity_en=0, parity_err stays 0.
- R6: If a sampled stop bit is 0, frame_err is 1 with that character's strobe. The data is still delivered. A line held low after a bad stop bit starts no new character until the line has returned high and fallen again.
- R7: With cfg_two_stop=1, two stop bits are sampled, and a low second stop bit alone sets frame_err. With cfg_two_stop=0, only one stop bit is sampled, and a start bit may follow it directly.
- R8: char_valid is high for exactly one clock per received character. parity_err and frame_err are valid in that cycle and are 0 outside it. char_data holds its value between strobes.
- R9: Bit timing restarts at every start edge, so characters sent back to back or after idle gaps of any length are each decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVERSAMPLE cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_serial | input | 1 | Serial line, idle high, asynchronous to clk |
| cfg_data_bits | input | 2 | Character length code (0..3 means 5..8 bits) |
| cfg_parity_en | input | 1 | 1 means a parity bit follows the data |
| cfg_parity_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_two_stop | input | 1 | 1 means two stop bits are sampled |
| char_data | output | MAX_BITS | Last received character, LSB aligned |
| char_valid | output | 1 | One-cycle strobe marking a new character |
| parity_err | output | 1 | Parity mismatch for the strobed character |
| frame_err | output | 1 | A stop bit was sampled low for the strobed character |

## Verification
A wrong state or counter in the controller shows up at the ports within one character time. A bit counter that is off by one shifts or truncates char_data. A wrongly chosen exit from the data or stop phases misplaces the parity and stop samples, which leads to spurious parity or framing flags or a missing strobe. A timer that does not restart at the start edge shows as drift across back-to-back characters. Sampling away from the midpoint shows as corrupted data when bits carry wrong values near their edges. A receiver stuck outside its idle state shows as a lost or extra strobe on the following character. The bench compares every strobe against a record it builds for each character it sends, and it also counts strobes, so extra or missing characters are caught.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP1  = 3'd4,
        RX_STOP2  = 3'd5
    } rx_state_e;

    // Shortest supported character length in bits
    localparam int unsigned RX_MIN_BITS = 5;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);

    // pipe[0..STAGES-1] is the synchroniser, pipe[STAGES] holds the previous value
    logic [STAGES:0] pipe;

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= 1'b1;
                    else        pipe[0] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b1;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign line_o = pipe[STAGES-1];
    assign fall_o = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic half_hit,
    output logic full_hit
);

    localparam int unsigned CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (restart || tick_cnt == FULL_LAST) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assign half_hit = (tick_cnt == HALF_LAST);
    assign full_hit = (tick_cnt == FULL_LAST);

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import rx_pkg::*;
#(
    parameter int unsigned MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_s,
    input  logic                line_fall,
    input  logic                half_hit,
    input  logic                full_hit,
    input  logic [1:0]          cfg_data_bits,
    input  logic                cfg_parity_en,
    input  logic                cfg_parity_odd,
    input  logic                cfg_two_stop,
    output logic                timer_restart,
    output logic [MAX_BITS-1:0] char_data,
    output logic                char_valid,
    output logic                parity_err,
    output logic                frame_err
);

    localparam int unsigned IDX_W = $clog2(MAX_BITS);

    rx_state_e           state_q, state_d;
    logic [IDX_W-1:0]    bit_idx;
    logic [MAX_BITS-1:0] shreg;
    logic                par_acc;
    logic                stop_bad;

    logic [IDX_W-1:0]    last_idx;
    logic                start_ok;
    logic                take_data;
    logic                emit;

    assign last_idx  = IDX_W'(RX_MIN_BITS - 1) + IDX_W'(cfg_data_bits);
    assign start_ok  = (state_q == RX_START) && half_hit && !line_s;
    assign take_data = (state_q == RX_DATA) && full_hit;
    assign emit      = full_hit &&
                       (((state_q == RX_STOP1) && !cfg_two_stop) ||
                         (state_q == RX_STOP2));

    // the timer is held at zero while waiting and restarted when the start bit is confirmed
    assign timer_restart = (state_q == RX_IDLE) || start_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (line_fall) state_d = RX_START;
            end
            RX_START: begin
                if (half_hit) state_d = line_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (full_hit && bit_idx == last_idx)
                    state_d = cfg_parity_en ? RX_PARITY : RX_STOP1;
            end
            RX_PARITY: begin
                if (full_hit) state_d = RX_STOP1;
            end
            RX_STOP1: begin
                if (full_hit) state_d = cfg_two_stop ? RX_STOP2 : RX_IDLE;
            end
            RX_STOP2: begin
                if (full_hit) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            stop_bad <= 1'b0;
        end else if (start_ok) begin
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            stop_bad <= 1'b0;
        end else if (take_data) begin
            shreg[bit_idx] <= line_s;
            par_acc        <= par_acc ^ line_s;
            bit_idx        <= bit_idx + 1'b1;
        end else if (full_hit && state_q == RX_PARITY) begin
            par_acc <= par_acc ^ line_s;
        end else if (full_hit && state_q == RX_STOP1) begin
            stop_bad <= ~line_s;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_valid <= 1'b0;
            char_data  <= '0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else if (emit) begin
            char_valid <= 1'b1;
            char_data  <= shreg;
            parity_err <= cfg_parity_en & (par_acc ^ cfg_parity_odd);
            frame_err  <= stop_bad | ~line_s;
        end else begin
            char_valid <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end
    end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx #(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned MAX_BITS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_serial,
    input  logic [1:0]          cfg_data_bits,
    input  logic                cfg_parity_en,
    input  logic                cfg_parity_odd,
    input  logic                cfg_two_stop,
    output logic [MAX_BITS-1:0] char_data,
    output logic                char_valid,
    output logic                parity_err,
    output logic                frame_err
);

    logic line_s;
    logic line_fall;
    logic timer_restart;
    logic half_hit;
    logic full_hit;

    rx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_serial),
        .line_o (line_s),
        .fall_o (line_fall)
    );

    rx_bit_timer #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (timer_restart),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    rx_frame_ctrl #(
        .MAX_BITS (MAX_BITS)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_s         (line_s),
        .line_fall      (line_fall),
        .half_hit       (half_hit),
        .full_hit       (full_hit),
        .cfg_data_bits  (cfg_data_bits),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_two_stop   (cfg_two_stop),
        .timer_restart  (timer_restart),
        .char_data      (char_data),
        .char_valid     (char_valid),
        .parity_err     (parity_err),
        .frame_err      (frame_err)
    );

endmodule

// File: rtl/async_char_rx_checks.sv
module async_char_rx_checks #(
    parameter int unsigned MAX_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cfg_data_bits,
    input logic                cfg_parity_en,
    input logic [MAX_BITS-1:0] char_data,
    input logic                char_valid,
    input logic                parity_err,
    input logic                frame_err
);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R8
    flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |-> !(parity_err || frame_err));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |-> $stable(char_data));

    // R5
    parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !cfg_parity_en) |-> !parity_err);

    // R3
    short_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && cfg_data_bits == 2'd0) |-> ((char_data >> 5) == '0));

endmodule

bind async_char_rx async_char_rx_checks #(
    .MAX_BITS (MAX_BITS)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_data_bits (cfg_data_bits),
    .cfg_parity_en (cfg_parity_en),
    .char_data     (char_data),
    .char_valid    (char_valid),
    .parity_err    (parity_err),
    .frame_err     (frame_err)
);

// File: tb/tb_async_char_rx.sv
module tb_async_char_rx;

    localparam int OS      = 16;
    localparam int W       = 8;
    localparam int DEPTH   = 256;
    localparam int WD_CYC  = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_serial = 1'b1;
    logic [1:0]   cfg_data_bits = 2'd3;
    logic         cfg_parity_en = 1'b0;
    logic         cfg_parity_odd = 1'b0;
    logic         cfg_two_stop = 1'b0;
    logic [W-1:0] char_data;
    logic         char_valid;
    logic         parity_err;
    logic         frame_err;

    always #10 clk = ~clk;

    async_char_rx dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_serial      (rx_serial),
        .cfg_data_bits  (cfg_data_bits),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_two_stop   (cfg_two_stop),
        .char_data      (char_data),
        .char_valid     (char_valid),
        .parity_err     (parity_err),
        .frame_err      (frame_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // captured strobes
    int           cap_cnt = 0;
    logic [W-1:0] cap_data [DEPTH];
    logic         cap_perr [DEPTH];
    logic         cap_ferr [DEPTH];

    // expected characters
    int           exp_cnt = 0;
    int           chk_idx = 0;
    logic [W-1:0] exp_data [DEPTH];
    logic         exp_perr [DEPTH];
    logic         exp_ferr [DEPTH];
    string        exp_tag  [DEPTH];

    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            cap_data[cap_cnt % DEPTH] = char_data;
            cap_perr[cap_cnt % DEPTH] = parity_err;
            cap_ferr[cap_cnt % DEPTH] = frame_err;
            cap_cnt++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mask_bits(input logic [W-1:0] d, input int nb);
        return d & W'((1 << nb) - 1);
    endfunction

    function automatic logic par_bit(input logic [W-1:0] d, input int nb, input bit odd);
        return (^mask_bits(d, nb)) ^ odd;
    endfunction

    task automatic idle(input int n);
        rx_serial = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v, input bit jit);
        for (int c = 0; c < OS; c++) begin
            rx_serial = (jit && (c < 3 || c > OS - 4)) ? ~v : v;
            @(negedge clk);
        end
    endtask

    task automatic send_char(input logic [W-1:0] d, input int nb, input bit pen,
                             input bit podd, input bit two, input bit bad_par,
                             input bit bad_s1, input bit bad_s2, input bit jit,
                             input string tag);
        cfg_data_bits  = 2'(nb - 5);
        cfg_parity_en  = pen;
        cfg_parity_odd = podd;
        cfg_two_stop   = two;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i], jit);
        if (pen) drive_bit(par_bit(d, nb, podd) ^ bad_par, 1'b0);
        drive_bit(~bad_s1, 1'b0);
        if (two) drive_bit(~bad_s2, 1'b0);
        exp_data[exp_cnt % DEPTH] = mask_bits(d, nb);
        exp_perr[exp_cnt % DEPTH] = pen & bad_par;
        exp_ferr[exp_cnt % DEPTH] = bad_s1 | (two & bad_s2);
        exp_tag [exp_cnt % DEPTH] = tag;
        exp_cnt++;
    endtask

    task automatic verify(input string tag);
        check({tag, " R8 strobe count"}, 32'(cap_cnt), 32'(exp_cnt));
        while (chk_idx < exp_cnt && chk_idx < cap_cnt) begin
            check({exp_tag[chk_idx % DEPTH], " R3 data"},
                  32'(cap_data[chk_idx % DEPTH]), 32'(exp_data[chk_idx % DEPTH]));
            check({exp_tag[chk_idx % DEPTH], " R5 parity_err"},
                  32'(cap_perr[chk_idx % DEPTH]), 32'(exp_perr[chk_idx % DEPTH]));
            check({exp_tag[chk_idx % DEPTH], " R6 frame_err"},
                  32'(cap_ferr[chk_idx % DEPTH]), 32'(exp_ferr[chk_idx % DEPTH]));
            chk_idx++;
        end
        chk_idx  = exp_cnt;
        cap_cnt  = exp_cnt;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 char_valid", 32'(char_valid), 32'd0);
        check("R1 parity_err", 32'(parity_err), 32'd0);
        check("R1 frame_err",  32'(frame_err),  32'd0);
        check("R1 char_data",  32'(char_data),  32'd0);
        idle(40);

        // R3 each length, no parity
        send_char(8'hA5, 8, 0, 0, 0, 0, 0, 0, 0, "R3 len8");
        idle(30);
        send_char(8'hFF, 5, 0, 0, 0, 0, 0, 0, 0, "R3 len5");
        idle(30);
        send_char(8'h2D, 6, 0, 0, 0, 0, 0, 0, 0, "R3 len6");
        idle(30);
        send_char(8'h5A, 7, 0, 0, 0, 0, 0, 0, 0, "R3 len7");
        idle(30);
        verify("R3");

        // R5 even and odd parity, good and bad
        send_char(8'h37, 8, 1, 0, 0, 0, 0, 0, 0, "R5 even ok");
        idle(20);
        send_char(8'h37, 8, 1, 0, 0, 1, 0, 0, 0, "R5 even bad");
        idle(20);
        send_char(8'h13, 7, 1, 1, 0, 0, 0, 0, 0, "R5 odd ok");
        idle(20);
        send_char(8'h00, 5, 1, 1, 0, 1, 0, 0, 0, "R5 odd bad");
        idle(20);
        verify("R5");

        // R6 bad stop bit, line held low afterwards, then high
        send_char(8'hC3, 8, 0, 0, 0, 0, 1, 0, 0, "R6 bad stop");
        rx_serial = 1'b0;
        repeat (3 * OS) @(negedge clk);
        idle(3 * OS);
        verify("R6");

        // R7 two stops with bad second stop, and good two-stop
        send_char(8'h81, 8, 1, 0, 1, 0, 0, 1, 0, "R7 bad stop2");
        idle(40);
        send_char(8'h7E, 8, 0, 0, 1, 0, 0, 0, 0, "R7 two stop ok");
        idle(40);
        verify("R7");

        // R2 short low pulses while idle produce nothing
        rx_serial = 1'b0;
        repeat (4) @(negedge clk);
        idle(50);
        rx_serial = 1'b0;
        repeat (6) @(negedge clk);
        idle(50);
        verify("R2 glitch");
        send_char(8'h96, 8, 0, 0, 0, 0, 0, 0, 0, "R2 after glitch");
        idle(30);
        verify("R2");

        // R4 bit edges corrupted
        send_char(8'h6C, 8, 1, 1, 0, 0, 0, 0, 1, "R4 edge noise");
        idle(30);
        send_char(8'h15, 5, 0, 0, 1, 0, 0, 0, 1, "R4 edge noise5");
        idle(30);
        verify("R4");

        // R9 and R7: back to back, one stop, no gap
        send_char(8'h01, 8, 0, 0, 0, 0, 0, 0, 0, "R9 b2b first");
        send_char(8'hFE, 8, 1, 0, 0, 0, 0, 0, 0, "R9 b2b second");
        send_char(8'h1F, 6, 0, 0, 0, 0, 0, 0, 0, "R9 b2b third");
        idle(30);
        verify("R9");

        // random characters with random gaps
        for (int n = 0; n < 40; n++) begin
            int nb = 5 + int'($urandom % 4);
            logic [W-1:0] d = W'($urandom);
            bit pen  = bit'($urandom % 2);
            bit podd = bit'($urandom % 2);
            bit two  = bit'($urandom % 2);
            bit bp   = bit'(($urandom % 5) == 0);
            bit jit  = bit'($urandom % 2);
            send_char(d, nb, pen, podd, two, bp, 0, 0, jit, "R9 random");
            idle(int'($urandom % 25));
        end
        idle(30);
        verify("R9 random");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule